// File: doc/BRIEF.md
# Condition-Code ALU with Predicate Evaluator

This block is a 32-bit integer execution slice that owns a four-bit condition-code register. Each accepted operation is an add that writes a result and sets all flags, a compare that subtracts the second operand from the first and updates only the flags, a bitwise test that ANDs the operands and updates only the flags, or an address-style add that writes a sum and leaves the flags alone. Operations are accepted on a clock edge when the valid strobe is high.

A four-bit condition selector picks one of eleven relations: always, equal, not equal, negative, non-negative, the four signed orderings, unsigned above and unsigned below. The selected relation is read from the registered flags and gives one predicate bit. A downstream branch unit uses it as the taken decision. A set-byte writeback uses the same bit, zero-extended to the word width.

Top module: `cc_alu`

## Requirements
- R1: While reset is low, and on the first clock after it, the result register and all four flags are zero.
- R2: Opcode 0 (add) registers a+b modulo 2^W as the result and sets the flags. CF is the carry out of the top bit, ZF means the sum is zero, SF is the top bit of the sum, and OF means the true signed sum does not fit in W bits.
- R3: Opcode 1 (compare) leaves the result unchanged. It sets CF when a is below b as unsigned numbers, ZF when a equals b, and SF to the top bit of a-b. OF means the true signed difference does not fit in W bits.
- R4: Opcode 2 (test) leaves the result unchanged. ZF means a AND b is zero and SF is the top bit of a AND b. CF and OF are cleared.
- R5: Opcode 3 (address add) registers a+b modulo 2^W as the result and leaves all four flags unchanged.
- R6: With the valid strobe low, neither the result nor the flags change, whatever the other inputs are.
- R7: The flags port packs CF in bit 0, ZF in bit 1, SF in bit 2 and OF in bit 3, and shows the registered flags one clock after the operation that set them.
- R8: The predicate is combinational in the selector and the registered flags. Selectors 0..10 give, in order: 1, ZF, ~ZF, SF, ~SF, ~(SF^OF)&~ZF, ~(SF^OF), SF^OF, (SF^OF)|ZF, ~CF&~ZF, CF.
- R9: Selectors 11 to 15 give a predicate of zero.
- R10: The set-byte output carries the predicate in bit 0, and all of its other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation accepted on this edge when high |
| op_i | input | 2 | Opcode: 0 add, 1 compare, 2 test, 3 address add |
| a_i | input | W (32) | First operand |
| b_i | input | W (32) | Second operand |
| sel_i | input | 4 | Condition selector |
| result_o | output | W (32) | Registered result |
| flags_o | output | 4 | Registered flags {OF, SF, ZF, CF} |
| pred_o | output | 1 | Selected predicate (branch-taken decision) |
| setbyte_o | output | W (32) | Predicate zero-extended to the word |

## Verification
The hardest cases to reach are the signed-overflow boundaries. Examples are compare with a zero or positive first operand against the most negative second operand, and add of two large positive operands that wraps negative. With a 32-bit word, random operands almost never land on them. The bench therefore shrinks the word to 8 bits. It sweeps every first operand against a dense set of second operands that includes 0x7F, 0x80 and every third value, for all four opcodes. After each operation it walks all sixteen selectors on the same registered flags, so every predicate is checked against every flag combination the sweep produces.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_CMP = 2'd1,
    OP_TST = 2'd2,
    OP_LEA = 2'd3
  } alu_op_e;

  // bit 0 carry, bit 1 zero, bit 2 sign, bit 3 overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic cry;
  } ccr_t;

  localparam int SEL_W  = 4;
  localparam int NCODES = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    CND_ALWAYS = 4'd0,
    CND_EQ     = 4'd1,
    CND_NE     = 4'd2,
    CND_NEG    = 4'd3,
    CND_NNEG   = 4'd4,
    CND_SGT    = 4'd5,
    CND_SGE    = 4'd6,
    CND_SLT    = 4'd7,
    CND_SLE    = 4'd8,
    CND_UA     = 4'd9,
    CND_UB     = 4'd10
  } cond_e;

  localparam int LAST_CODE = 10;

endpackage

// File: rtl/cc_flag_calc.sv
module cc_flag_calc
  import cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      valid_i,
  input  alu_op_e   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output ccr_t      nxt_flags_o,
  output logic      wr_flags_o,
  output logic      wr_result_o
);

  function automatic ccr_t add_cc(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] t;
    ccr_t f;
    t     = {1'b0, x} + {1'b0, y};
    f.cry = t[W];
    f.zro = ~|t[W-1:0];
    f.sgn = t[W-1];
    f.ovf = (x[W-1] == y[W-1]) && (t[W-1] != x[W-1]);
    return f;
  endfunction

  function automatic ccr_t sub_cc(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] t;
    ccr_t f;
    t     = {1'b0, x} - {1'b0, y};
    f.cry = t[W];
    f.zro = ~|t[W-1:0];
    f.sgn = t[W-1];
    f.ovf = (x[W-1] != y[W-1]) && (t[W-1] != x[W-1]);
    return f;
  endfunction

  function automatic ccr_t and_cc(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] m;
    ccr_t f;
    m     = x & y;
    f.cry = 1'b0;
    f.zro = ~|m;
    f.sgn = m[W-1];
    f.ovf = 1'b0;
    return f;
  endfunction

  assign sum_o = a_i + b_i;

  always_comb begin
    unique case (op_i)
      OP_ADD:  nxt_flags_o = add_cc(a_i, b_i);
      OP_CMP:  nxt_flags_o = sub_cc(a_i, b_i);
      OP_TST:  nxt_flags_o = and_cc(a_i, b_i);
      default: nxt_flags_o = '0;
    endcase
  end

  assign wr_flags_o  = valid_i && (op_i != OP_LEA);
  assign wr_result_o = valid_i && ((op_i == OP_ADD) || (op_i == OP_LEA));

endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  ccr_t nxt_i,
  output ccr_t flags_q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)       flags_q_o <= '0;
    else if (wr_en_i) flags_q_o <= nxt_i;
  end

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(flags_q_o));

  // R7
  flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (flags_q_o == $past(nxt_i)));

endmodule

// File: rtl/cc_pred_eval.sv
module cc_pred_eval
  import cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ccr_t             flags_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pred_o
);

  function automatic logic cond_fn(input int unsigned code, input ccr_t f);
    logic lt;
    lt = f.sgn ^ f.ovf;
    case (code)
      0:       return 1'b1;
      1:       return f.zro;
      2:       return ~f.zro;
      3:       return f.sgn;
      4:       return ~f.sgn;
      5:       return ~lt & ~f.zro;
      6:       return ~lt;
      7:       return lt;
      8:       return lt | f.zro;
      9:       return ~f.cry & ~f.zro;
      10:      return f.cry;
      default: return 1'b0;
    endcase
  endfunction

  logic [NCODES-1:0] tbl;

  genvar k;
  generate
    for (k = 0; k < NCODES; k++) begin : g_cond
      assign tbl[k] = cond_fn(k, flags_i);
    end
  endgenerate

  assign pred_o = tbl[sel_i];

  // R9
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_i) > LAST_CODE) |-> !pred_o);

  // R8
  eq_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == CND_EQ) |-> (pred_o == flags_i.zro));

  // R8
  ge_lt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == CND_SLT) |-> (pred_o == (flags_i.sgn != flags_i.ovf)));

endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     result_o,
  output logic [3:0]       flags_o,
  output logic             pred_o,
  output logic [W-1:0]     setbyte_o
);

  alu_op_e      op_e;
  logic [W-1:0] sum_w;
  ccr_t         nxt_flags_w;
  ccr_t         flags_q;
  logic         wr_flags_w;
  logic         wr_result_w;
  logic         pred_w;

  assign op_e = alu_op_e'(op_i);

  cc_flag_calc #(.W(W)) u_calc (
    .valid_i     (valid_i),
    .op_i        (op_e),
    .a_i         (a_i),
    .b_i         (b_i),
    .sum_o       (sum_w),
    .nxt_flags_o (nxt_flags_w),
    .wr_flags_o  (wr_flags_w),
    .wr_result_o (wr_result_w)
  );

  cc_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_flags_w),
    .nxt_i     (nxt_flags_w),
    .flags_q_o (flags_q)
  );

  cc_pred_eval u_pred (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags_q),
    .sel_i   (sel_i),
    .pred_o  (pred_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           result_o <= '0;
    else if (wr_result_w) result_o <= sum_w;
  end

  assign flags_o   = flags_q;
  assign pred_o    = pred_w;
  assign setbyte_o = {{(W-1){1'b0}}, pred_w};

  // R2
  add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd0) |=> (result_o == W'($past(a_i) + $past(b_i))));

  // R3
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd1) |=> (flags_o[1] == ($past(a_i) == $past(b_i))));

  // R3
  cmp_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd1) |=> (flags_o[0] == ($past(a_i) < $past(b_i))));

  // R4
  tst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd2) |=> (!flags_o[0] && !flags_o[3]));

  // R3
  nodest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i[1] != op_i[0]) |=> $stable(result_o));

  // R5
  lea_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd3) |=> $stable(flags_o));

  // R10
  setbyte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setbyte_o[W-1:1] == '0) && (setbyte_o[0] == pred_o));

endmodule

// File: tb/cc_alu_bench.sv
`timescale 1ns/10ps
module cc_alu_bench;

  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid;
  logic [1:0]    op;
  logic [TW-1:0] a, b;
  logic [3:0]    sel;
  logic [TW-1:0] result;
  logic [3:0]    flags;
  logic          pred;
  logic [TW-1:0] setbyte;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [TW-1:0] exp_res;
  logic [3:0]    exp_f;   // {OF, SF, ZF, CF}

  always #2.5 clk = ~clk;

  cc_alu #(.W(TW)) u_cc_alu (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .sel_i(sel), .result_o(result), .flags_o(flags), .pred_o(pred),
    .setbyte_o(setbyte)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h sel=%0d)",
               rq, what, act, expv, op, a, b, sel);
    end
  endtask

  function automatic logic exp_pred(input logic [3:0] f, input int s);
    logic c, z, sg, o;
    {o, sg, z, c} = f;
    case (s)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return sg;
      4: return !sg;
      5: return (sg == o) && !z;
      6: return sg == o;
      7: return sg != o;
      8: return (sg != o) || z;
      9: return !c && !z;
      10: return c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep_sel(input string rq);
    for (int s = 0; s < 16; s++) begin
      sel = 4'(s);
      #0.1;
      chk((s > 10) ? "R9" : rq, "pred", {31'd0, pred}, {31'd0, exp_pred(exp_f, s)});
      chk("R10", "setbyte", {24'd0, setbyte}, {31'd0, exp_pred(exp_f, s)});
    end
  endtask

  task automatic run_op(input logic v, input int o, input int ua, input int ub);
    int sa, sb, full, r;
    string rq;
    @(negedge clk);
    valid = v; op = 2'(o); a = TW'(ua); b = TW'(ub);
    sa = (ua >= 128) ? ua - 256 : ua;
    sb = (ub >= 128) ? ub - 256 : ub;
    rq = "R6";
    if (v) begin
      case (o)
        0: begin
          rq = "R2"; full = ua + ub; r = full % 256; exp_res = TW'(r);
          exp_f = {(sa + sb > 127) || (sa + sb < -128), r >= 128, r == 0, full > 255};
        end
        1: begin
          rq = "R3"; r = (ua - ub + 256) % 256;
          exp_f = {(sa - sb > 127) || (sa - sb < -128), r >= 128, ua == ub, ua < ub};
        end
        2: begin
          rq = "R4"; r = ua & ub;
          exp_f = {1'b0, r >= 128, r == 0, 1'b0};
        end
        default: begin
          rq = "R5"; exp_res = TW'((ua + ub) % 256);
        end
      endcase
    end
    @(posedge clk);
    #0.5;
    chk(rq, "result", {24'd0, result}, {24'd0, exp_res});
    chk((rq == "R2") ? "R7" : rq, "flags", {28'd0, flags}, {28'd0, exp_f});
    sweep_sel("R8");
    valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 195000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; valid = 1'b1; op = 2'd0; a = 8'hFF; b = 8'h01; sel = 4'd0;
    exp_res = '0; exp_f = '0;
    repeat (3) @(posedge clk);
    #0.5;
    // R1: reset holds everything at zero despite valid input activity
    chk("R1", "result", {24'd0, result}, 32'd0);
    chk("R1", "flags", {28'd0, flags}, 32'd0);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #0.5;
    chk("R1", "result", {24'd0, result}, 32'd0);
    chk("R1", "flags", {28'd0, flags}, 32'd0);

    // directed overflow corners
    run_op(1, 1, 8'h00, 8'h80);  // R3 0 - (-128) overflows
    run_op(1, 0, 8'h7F, 8'h01);  // R2 positive wrap
    run_op(1, 0, 8'h80, 8'h80);  // R2 negative wrap, carry, zero
    run_op(1, 3, 8'h10, 8'h20);  // R5 flags kept from previous add
    // R6: invalid ops with values that would change everything
    run_op(0, 2, 8'h00, 8'h00);
    run_op(0, 0, 8'h7F, 8'h7F);
    run_op(1, 2, 8'hF0, 8'h0F);  // R4 zero AND
    run_op(1, 2, 8'hF0, 8'h80);  // R4 negative AND

    for (int o = 0; o < 4; o++)
      for (int ua = 0; ua < 256; ua++)
        for (int ub = 0; ub < 256; ub++)
          if ((ub % 3 == 0) || ub == 1 || ub == 127 || ub == 128)
            run_op(1, o, ua, ub);

    // R1: reset after activity clears state again
    run_op(1, 1, 8'h01, 8'h02);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #0.5;
    chk("R1", "result", {24'd0, result}, 32'd0);
    chk("R1", "flags", {28'd0, flags}, 32'd0);
    finish_run();
  end

endmodule